// File: doc/BRIEF.md
# Seven-Channel Memory/Peripheral DMA Controller

This block moves data between peripheral registers and memory so that a processor does not have to run load/store loops. Seven channels each hold a peripheral address, a memory address, a transfer count and a configuration word. A channel becomes pending when its peripheral raises a request pulse or when software pulses its trigger bit. Each served request performs one transfer: a read beat on a single-master bus followed by a write beat. The transfer count falls by one for every completed transfer. When it reaches zero, a normal channel goes quiet. A circular channel reloads its count and both addresses from their programmed bases and keeps serving requests.

An arbiter picks one pending channel whenever the engine is idle. The highest software priority level wins, and among channels at the same level the lowest channel number wins. The engine is a three-state machine. In EN_IDLE a grant moves it to EN_READ, the "start" transition. In EN_READ an acknowledge without error moves it to EN_WRITE ("read done"), and an acknowledge with error returns it to EN_IDLE ("read fault"). In EN_WRITE any acknowledge returns it to EN_IDLE, either as "write done" or as "write fault".

Each channel keeps half-transfer, transfer-complete and transfer-error flags. Each flag is gated by its own enable into a per-channel interrupt line. Software sets up a channel through a simple register write port and reads state back through a combinational read port.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, every count, address and configuration reads back as zero, all flags and interrupts are low, and the bus request is low.
- R2: The configuration word is laid out as follows, with each field active when its bit is 1: bit 0 enable, bit 1 direction, bit 2 peripheral increment, bit 3 memory increment, bit 4 circular, bits 6:5 peripheral size, bits 8:7 memory size, bits 10:9 priority, bit 11 half-transfer interrupt enable, bit 12 complete interrupt enable, bit 13 error interrupt enable. Direction 0 reads from the peripheral address and writes to the memory address. Direction 1 reads from memory and writes to the peripheral. Each transfer is one read beat followed by one write beat, and the bus holds its request, address and direction until acknowledged.
- R3: After each completed transfer, an address advances by its side's size in bytes (1, 2 or 4) only if that side's increment bit is set; otherwise the address stays fixed.
- R4: A size code of 0 means byte, 1 means halfword, and 2 or 3 means word. The read uses the source side's size, and the read data is zero-extended or truncated to the destination side's size before it is written.
- R5: The count decrements once per completed transfer. In normal mode, reaching zero sets the complete flag, and the channel then ignores further requests.
- R6: In circular mode, reaching zero sets the complete flag and reloads the count and both addresses from their programmed values, and the channel keeps serving requests.
- R7: The half-transfer flag sets when the remaining count after a transfer equals the programmed count divided by two, rounded down.
- R8: Among pending channels, the higher priority value wins (3 very high, 0 low), and a tie goes to the lower channel number.
- R9: An error response on either beat sets the channel's error flag, clears its enable and leaves its count unchanged.
- R10: Writes to the address and count registers (selector 0 peripheral, 1 memory, 2 count; selector 3 is configuration) are ignored while the channel is enabled.
- R11: A channel's interrupt is high exactly when one of its flags is set together with that flag's enable. A clear pulse for the channel drops all three of its flags.
- R12: A hardware request pulse or a software trigger pulse each make an enabled channel pending. A disabled channel drops pending state and ignores requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 3 | Channel addressed by the write |
| reg_sel | input | 2 | Register selector for the write |
| reg_wdata | input | 32 | Write data |
| rd_ch | input | 3 | Channel addressed by the read port |
| rd_sel | input | 2 | Register selector for the read port |
| rd_data | output | 32 | Current address, count or configuration |
| hw_req | input | 7 | Per-channel peripheral request pulses |
| sw_trig | input | 7 | Per-channel software trigger pulses |
| flag_clr | input | 7 | Per-channel flag clear pulses |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_addr | output | 32 | Byte address of the beat |
| bus_size | output | 2 | Size code of the beat |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_rdata | input | 32 | Read data, right-aligned |
| bus_ack | input | 1 | Beat acknowledge |
| bus_err | input | 1 | Error response, valid with acknowledge |
| ht_flag | output | 7 | Half-transfer flags |
| tc_flag | output | 7 | Transfer-complete flags |
| te_flag | output | 7 | Transfer-error flags |
| irq | output | 7 | Per-channel interrupts |

## Verification
The bench targets the end of a block. It checks that a normal channel stops exactly at zero, where a design with an off-by-one in the count check would issue an extra bus access. It also checks that a circular channel returns to its base memory address, where a design that reloaded only the count would write past the buffer. Mixed source and destination sizes catch a design that masks data with the wrong side's size and leaves stray upper bytes. Simultaneous requests at mixed priorities catch an arbiter that ignores the level or breaks ties toward the higher channel number. An error beat shows whether the enable is really cleared, because a design that left it set would keep retrying.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int DATA_W = 32;

    typedef struct packed {
        logic       te_ie;
        logic       tc_ie;
        logic       ht_ie;
        logic [1:0] prio;
        logic [1:0] msize;
        logic [1:0] psize;
        logic       circ;
        logic       minc;
        logic       pinc;
        logic       dir;
        logic       en;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    typedef enum logic [1:0] {
        EN_IDLE  = 2'd0,
        EN_READ  = 2'd1,
        EN_WRITE = 2'd2
    } eng_state_e;

    localparam logic [1:0] SEL_PADDR = 2'd0;
    localparam logic [1:0] SEL_MADDR = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_CFG   = 2'd3;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] code);
        case (code)
            2'd0:    return DATA_W'(32'h0000_00FF);
            2'd1:    return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trig,
    input  logic              flag_clr,
    input  logic              done_ok,
    input  logic              done_err,
    output chan_cfg_t         cfg,
    output logic [AW-1:0]     cur_pa,
    output logic [AW-1:0]     cur_ma,
    output logic [CW-1:0]     cur_cnt,
    output logic              eligible,
    output logic              ht,
    output logic              tc,
    output logic              te,
    output logic              irq
);

    chan_cfg_t     cfg_q;
    logic [AW-1:0] base_pa, base_ma, pa_q, ma_q;
    logic [CW-1:0] base_cnt, cnt_q, cnt_dec;
    logic [AW-1:0] pa_next, ma_next;
    logic          pend_q, ht_q, tc_q, te_q;

    always_comb begin
        cnt_dec = cnt_q - CW'(1);
        pa_next = pa_q + (cfg_q.pinc ? AW'(size_bytes(cfg_q.psize)) : '0);
        ma_next = ma_q + (cfg_q.minc ? AW'(size_bytes(cfg_q.msize)) : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            base_pa  <= '0;
            base_ma  <= '0;
            base_cnt <= '0;
            pa_q     <= '0;
            ma_q     <= '0;
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            ht_q     <= 1'b0;
            tc_q     <= 1'b0;
            te_q     <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    SEL_PADDR: if (!cfg_q.en) begin
                        base_pa <= wr_data[AW-1:0];
                        pa_q    <= wr_data[AW-1:0];
                    end
                    SEL_MADDR: if (!cfg_q.en) begin
                        base_ma <= wr_data[AW-1:0];
                        ma_q    <= wr_data[AW-1:0];
                    end
                    SEL_COUNT: if (!cfg_q.en) begin
                        base_cnt <= wr_data[CW-1:0];
                        cnt_q    <= wr_data[CW-1:0];
                    end
                    default: cfg_q <= wr_data[CFG_W-1:0];
                endcase
            end

            if (!cfg_q.en)    pend_q <= 1'b0;
            else if (trig)    pend_q <= 1'b1;
            else if (done_ok) pend_q <= 1'b0;

            if (flag_clr) begin
                ht_q <= 1'b0;
                tc_q <= 1'b0;
                te_q <= 1'b0;
            end

            if (done_ok) begin
                if (cnt_dec == (base_cnt >> 1)) ht_q <= 1'b1;
                if (cnt_dec == '0) begin
                    tc_q <= 1'b1;
                    if (cfg_q.circ) begin
                        cnt_q <= base_cnt;
                        pa_q  <= base_pa;
                        ma_q  <= base_ma;
                    end else begin
                        cnt_q <= '0;
                        pa_q  <= pa_next;
                        ma_q  <= ma_next;
                    end
                end else begin
                    cnt_q <= cnt_dec;
                    pa_q  <= pa_next;
                    ma_q  <= ma_next;
                end
            end

            if (done_err) begin
                te_q      <= 1'b1;
                cfg_q.en  <= 1'b0;
                pend_q    <= 1'b0;
            end
        end
    end

    assign cfg      = cfg_q;
    assign cur_pa   = pa_q;
    assign cur_ma   = ma_q;
    assign cur_cnt  = cnt_q;
    assign eligible = pend_q && cfg_q.en && (cnt_q != '0);
    assign ht       = ht_q;
    assign tc       = tc_q;
    assign te       = te_q;
    assign irq      = (ht_q && cfg_q.ht_ie) || (tc_q && cfg_q.tc_ie) || (te_q && cfg_q.te_ie);

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
    parameter int NCH = 7,
    parameter int CHW = 3
) (
    input  logic [NCH-1:0] eligible,
    input  logic [1:0]     prio [NCH],
    output logic           valid,
    output logic [CHW-1:0] grant
);

    logic [1:0] best;

    // Scan from the top channel down; ">=" lets a lower number take a tie.
    always_comb begin
        valid = 1'b0;
        grant = '0;
        best  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (eligible[i] && (!valid || prio[i] >= best)) begin
                valid = 1'b1;
                grant = CHW'(i);
                best  = prio[i];
            end
        end
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CHW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_valid,
    input  logic [CHW-1:0]    grant_ch,
    input  logic [AW-1:0]     grant_src,
    input  logic [AW-1:0]     grant_dst,
    input  logic [1:0]        grant_ssz,
    input  logic [1:0]        grant_dsz,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [CHW-1:0]    act_ch,
    output logic              done_ok,
    output logic              done_err
);

    eng_state_e        state_q, state_d;
    logic [CHW-1:0]    ch_q;
    logic [AW-1:0]     src_q, dst_q;
    logic [1:0]        ssz_q, dsz_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_IDLE:  if (grant_valid) state_d = EN_READ;
            EN_READ:  if (bus_ack) state_d = bus_err ? EN_IDLE : EN_WRITE;
            EN_WRITE: if (bus_ack) state_d = EN_IDLE;
            default:  state_d = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EN_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q   <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            ssz_q  <= '0;
            dsz_q  <= '0;
            data_q <= '0;
        end else begin
            if (state_q == EN_IDLE && grant_valid) begin
                ch_q  <= grant_ch;
                src_q <= grant_src;
                dst_q <= grant_dst;
                ssz_q <= grant_ssz;
                dsz_q <= grant_dsz;
            end
            if (state_q == EN_READ && bus_ack && !bus_err)
                data_q <= bus_rdata & size_mask(ssz_q);
        end
    end

    always_comb begin
        bus_req   = (state_q != EN_IDLE);
        bus_we    = (state_q == EN_WRITE);
        bus_addr  = (state_q == EN_WRITE) ? dst_q : src_q;
        bus_size  = (state_q == EN_WRITE) ? dsz_q : ssz_q;
        bus_wdata = data_q & size_mask(dsz_q);
        act_ch    = ch_q;
        done_ok   = (state_q == EN_WRITE) && bus_ack && !bus_err;
        done_err  = (state_q != EN_IDLE) && bus_ack && bus_err;
    end

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int NCH = 7,
    parameter int AW  = 32,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [CHW-1:0]    reg_ch,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CHW-1:0]    rd_ch,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NCH-1:0]    hw_req,
    input  logic [NCH-1:0]    sw_trig,
    input  logic [NCH-1:0]    flag_clr,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic [NCH-1:0]    ht_flag,
    output logic [NCH-1:0]    tc_flag,
    output logic [NCH-1:0]    te_flag,
    output logic [NCH-1:0]    irq
);

    chan_cfg_t      cfg_a [NCH];
    logic [AW-1:0]  pa_a  [NCH];
    logic [AW-1:0]  ma_a  [NCH];
    logic [CW-1:0]  cnt_a [NCH];
    logic [1:0]     prio_a [NCH];
    logic [NCH-1:0] elig;

    logic           grant_valid, done_ok, done_err;
    logic [CHW-1:0] grant_ch, act_ch;
    logic [AW-1:0]  grant_src, grant_dst;
    logic [1:0]     grant_ssz, grant_dsz;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign prio_a[g] = cfg_a[g].prio;

        dma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && (reg_ch == CHW'(g))),
            .wr_sel   (reg_sel),
            .wr_data  (reg_wdata),
            .trig     (hw_req[g] | sw_trig[g]),
            .flag_clr (flag_clr[g]),
            .done_ok  (done_ok && (act_ch == CHW'(g))),
            .done_err (done_err && (act_ch == CHW'(g))),
            .cfg      (cfg_a[g]),
            .cur_pa   (pa_a[g]),
            .cur_ma   (ma_a[g]),
            .cur_cnt  (cnt_a[g]),
            .eligible (elig[g]),
            .ht       (ht_flag[g]),
            .tc       (tc_flag[g]),
            .te       (te_flag[g]),
            .irq      (irq[g])
        );
    end

    dma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
        .eligible (elig),
        .prio     (prio_a),
        .valid    (grant_valid),
        .grant    (grant_ch)
    );

    // Route the winner's source and destination by its direction bit.
    always_comb begin
        grant_src = '0;
        grant_dst = '0;
        grant_ssz = '0;
        grant_dsz = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant_ch == CHW'(i)) begin
                if (cfg_a[i].dir) begin
                    grant_src = ma_a[i];
                    grant_ssz = cfg_a[i].msize;
                    grant_dst = pa_a[i];
                    grant_dsz = cfg_a[i].psize;
                end else begin
                    grant_src = pa_a[i];
                    grant_ssz = cfg_a[i].psize;
                    grant_dst = ma_a[i];
                    grant_dsz = cfg_a[i].msize;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CHW'(i)) begin
                case (rd_sel)
                    SEL_PADDR: rd_data = DATA_W'(pa_a[i]);
                    SEL_MADDR: rd_data = DATA_W'(ma_a[i]);
                    SEL_COUNT: rd_data = DATA_W'(cnt_a[i]);
                    default:   rd_data = DATA_W'(cfg_a[i]);
                endcase
            end
        end
    end

    dma_engine #(.AW(AW), .CHW(CHW)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (grant_valid),
        .grant_ch    (grant_ch),
        .grant_src   (grant_src),
        .grant_dst   (grant_dst),
        .grant_ssz   (grant_ssz),
        .grant_dsz   (grant_dsz),
        .bus_rdata   (bus_rdata),
        .bus_ack     (bus_ack),
        .bus_err     (bus_err),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .bus_wdata   (bus_wdata),
        .act_ch      (act_ch),
        .done_ok     (done_ok),
        .done_err    (done_err)
    );

endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
    parameter int NCH = 7,
    parameter int AW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_ack,
    input logic           bus_err,
    input logic [CHW-1:0] act_ch,
    input logic [NCH-1:0] ht_flag,
    input logic [NCH-1:0] tc_flag,
    input logic [NCH-1:0] te_flag,
    input logic [NCH-1:0] irq
);

    logic           err_seen;
    logic [CHW-1:0] err_ch;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_seen <= 1'b0;
            err_ch   <= '0;
        end else begin
            err_seen <= bus_req && bus_ack && bus_err;
            err_ch   <= act_ch;
        end
    end

    // R2: a beat keeps its request, address and direction until acknowledged
    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R2: a clean read beat is always followed by a write beat
    a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && !bus_we && !bus_err |=> bus_req && bus_we);

    // R9: an error response leaves the serving channel's error flag set
    a_r9_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_seen |-> te_flag[err_ch]);

    // R5: a complete flag rises only after a clean write beat
    a_r5_tc_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_flag & ~$past(tc_flag)) != '0 |-> $past(bus_req && bus_ack && bus_we && !bus_err));

    // R11: no interrupt without a set flag behind it
    a_r11_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~(ht_flag | tc_flag | te_flag)) == '0);

endmodule

bind dma_ctrl dma_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .act_ch   (act_ch),
    .ht_flag  (ht_flag),
    .tc_flag  (tc_flag),
    .te_flag  (te_flag),
    .irq      (irq)
);

// File: tb/sim_dma_ctrl.sv
`timescale 1ns/1ps
module sim_dma_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_ch = '0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  rd_ch = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [6:0]  hw_req = '0, sw_trig = '0, flag_clr = '0;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic [6:0]  ht_flag, tc_flag, te_flag, irq;

    int n_chk = 0, n_fail = 0, n_bus = 0, wcnt = 0;
    bit finished = 0;
    logic [7:0] mem [256];
    logic [7:0] wlog [64];

    always #4 clk = ~clk;

    dma_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
        .hw_req(hw_req), .sw_trig(sw_trig), .flag_clr(flag_clr),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .ht_flag(ht_flag), .tc_flag(tc_flag), .te_flag(te_flag), .irq(irq)
    );

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] mword(input int a);
        return {mem[(a+3)&255], mem[(a+2)&255], mem[(a+1)&255], mem[a&255]};
    endfunction

    // Bus slave: acknowledge every other cycle; addresses 0xF0-0xFF answer with an error.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0;
            bus_err = 1'b0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
            bus_err = 1'b0;
        end else if (bus_req) begin
            int a;
            a = int'(bus_addr[7:0]);
            bus_ack = 1'b1;
            bus_err = (bus_addr[7:0] >= 8'hF0);
            n_bus++;
            if (!bus_we) begin
                bus_rdata = '0;
                for (int k = 0; k < nbytes(bus_size); k++)
                    bus_rdata[8*k +: 8] = mem[(a+k)&255];
            end else if (!bus_err) begin
                for (int k = 0; k < nbytes(bus_size); k++)
                    mem[(a+k)&255] = bus_wdata[8*k +: 8];
                if (wcnt < 64) wlog[wcnt] = bus_addr[7:0];
                wcnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_ch = 3'(ch); reg_sel = 2'(sel); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int sel, output logic [31:0] v);
        rd_ch = 3'(ch); rd_sel = 2'(sel);
        #1;
        v = rd_data;
    endtask

    function automatic logic [31:0] cfgw(input bit en, dir, pinc, minc, circ,
                                         input logic [1:0] psz, msz, pr,
                                         input bit htie, tcie, teie);
        return 32'({teie, tcie, htie, pr, msz, psz, circ, minc, pinc, dir, en});
    endfunction

    task automatic setup(input int ch, input logic [31:0] pa, ma, cnt, cfg);
        wr_reg(ch, 3, 32'd0);
        wr_reg(ch, 0, pa);
        wr_reg(ch, 1, ma);
        wr_reg(ch, 2, cnt);
        wr_reg(ch, 3, cfg);
    endtask

    task automatic fire(input logic [6:0] hw, input logic [6:0] sw, input int wait_cyc);
        @(negedge clk);
        hw_req = hw; sw_trig = sw;
        @(negedge clk);
        hw_req = '0; sw_trig = '0;
        repeat (wait_cyc) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(0, 2, v); chk("R1 count", v, 0);
        rd(3, 3, v); chk("R1 cfg", v, 0);
        rd(6, 1, v); chk("R1 maddr", v, 0);
        chk("R1 flags", {ht_flag, tc_flag, te_flag, irq}, 0);
        chk("R1 bus_req", 32'(bus_req), 0);
    endtask

    task automatic t_periph_to_mem;
        logic [31:0] v;
        int nb;
        {mem[8'h13], mem[8'h12], mem[8'h11], mem[8'h10]} = 32'hEFBEADDE;
        setup(0, 32'h10, 32'h40, 2, cfgw(1, 0, 0, 1, 0, 2'd2, 2'd2, 2'd0, 0, 1, 0));
        fire(7'h01, 7'h00, 12);
        chk("R2 dir0 first word", mword(8'h40), 32'hEFBEADDE);
        chk("R7 half flag at 1 of 2", 32'(ht_flag[0]), 1);
        chk("R5 no tc yet", 32'(tc_flag[0]), 0);
        rd(0, 2, v); chk("R5 count 1", v, 1);
        rd(0, 0, v); chk("R3 fixed paddr", v, 32'h10);
        rd(0, 1, v); chk("R3 word maddr step", v, 32'h44);
        fire(7'h01, 7'h00, 12);
        chk("R2 dir0 second word", mword(8'h44), 32'hEFBEADDE);
        chk("R5 tc at zero", 32'(tc_flag[0]), 1);
        chk("R11 irq from tc", 32'(irq[0]), 1);
        nb = n_bus;
        fire(7'h01, 7'h00, 12);
        chk("R5 stopped bus count", 32'(n_bus), 32'(nb));
        chk("R5 no write past end", mword(8'h48), 0);
    endtask

    task automatic t_mem_to_periph_bytes;
        logic [31:0] v;
        mem[8'h60] = 8'h11; mem[8'h61] = 8'h22; mem[8'h62] = 8'h33;
        setup(1, 32'h80, 32'h60, 3, cfgw(1, 1, 1, 1, 0, 2'd0, 2'd0, 2'd0, 0, 0, 0));
        for (int i = 0; i < 3; i++) fire(7'h00, 7'h02, 12);
        chk("R2 dir1 R12 sw bytes", mword(8'h80), 32'h00332211);
        rd(1, 0, v); chk("R3 byte paddr step", v, 32'h83);
        rd(1, 1, v); chk("R3 byte maddr step", v, 32'h63);
        chk("R11 tc set but masked", {31'd0, irq[1]}, 0);
        chk("R5 tc ch1", 32'(tc_flag[1]), 1);
    endtask

    task automatic t_sizes;
        {mem[8'h23], mem[8'h22], mem[8'h21], mem[8'h20]} = 32'hCAFEBABE;
        for (int i = 0; i < 4; i++) begin
            mem[8'h50 + i] = 8'hFF;
            mem[8'h58 + i] = 8'hFF;
        end
        setup(2, 32'h20, 32'h50, 1, cfgw(1, 0, 0, 0, 0, 2'd1, 2'd2, 2'd0, 0, 0, 0));
        fire(7'h04, 7'h00, 12);
        chk("R4 half to word", mword(8'h50), 32'h0000BABE);
        setup(2, 32'h20, 32'h58, 1, cfgw(1, 0, 0, 0, 0, 2'd2, 2'd0, 2'd0, 0, 0, 0));
        fire(7'h04, 7'h00, 12);
        chk("R4 word to byte", mword(8'h58), 32'hFFFFFFBE);
    endtask

    task automatic t_circular;
        logic [31:0] v;
        {mem[8'h33], mem[8'h32], mem[8'h31], mem[8'h30]} = 32'h01020304;
        setup(3, 32'h30, 32'h70, 2, cfgw(1, 0, 0, 1, 1, 2'd2, 2'd2, 2'd0, 0, 0, 0));
        fire(7'h08, 7'h00, 12);
        fire(7'h08, 7'h00, 12);
        rd(3, 2, v); chk("R6 count reloaded", v, 2);
        rd(3, 1, v); chk("R6 maddr reloaded", v, 32'h70);
        chk("R6 tc in circular", 32'(tc_flag[3]), 1);
        {mem[8'h33], mem[8'h32], mem[8'h31], mem[8'h30]} = 32'hAABBCCDD;
        fire(7'h08, 7'h00, 12);
        chk("R6 keeps running at base", mword(8'h70), 32'hAABBCCDD);
        rd(3, 2, v); chk("R6 count after wrap", v, 1);
    endtask

    task automatic t_priority;
        int base;
        setup(1, 32'h10, 32'h90, 1, cfgw(1, 0, 0, 0, 0, 2'd2, 2'd2, 2'd0, 0, 0, 0));
        setup(4, 32'h10, 32'h94, 1, cfgw(1, 0, 0, 0, 0, 2'd2, 2'd2, 2'd3, 0, 0, 0));
        setup(5, 32'h10, 32'h98, 1, cfgw(1, 0, 0, 0, 0, 2'd2, 2'd2, 2'd3, 0, 0, 0));
        setup(6, 32'h10, 32'h9C, 1, cfgw(1, 0, 0, 0, 0, 2'd2, 2'd2, 2'd2, 0, 0, 0));
        base = wcnt;
        fire(7'h72, 7'h00, 40);
        chk("R8 first very-high low number", 32'(wlog[base]), 32'h94);
        chk("R8 second very-high", 32'(wlog[base+1]), 32'h98);
        chk("R8 third high", 32'(wlog[base+2]), 32'h9C);
        chk("R8 last low", 32'(wlog[base+3]), 32'h90);
    endtask

    task automatic t_error;
        logic [31:0] v;
        int nb;
        setup(6, 32'h10, 32'hF0, 2, cfgw(1, 0, 0, 1, 0, 2'd2, 2'd2, 2'd0, 0, 0, 1));
        fire(7'h40, 7'h00, 12);
        chk("R9 te flag", 32'(te_flag[6]), 1);
        rd(6, 3, v); chk("R9 enable cleared", v & 32'h1, 0);
        rd(6, 2, v); chk("R9 count kept", v, 2);
        chk("R11 irq from te", 32'(irq[6]), 1);
        nb = n_bus;
        fire(7'h40, 7'h00, 12);
        chk("R12 disabled after error ignores", 32'(n_bus), 32'(nb));
    endtask

    task automatic t_protect_clear_ignore;
        logic [31:0] v;
        int nb;
        wr_reg(0, 2, 32'd5);
        rd(0, 2, v); chk("R10 count locked", v, 0);
        wr_reg(0, 0, 32'hA0);
        rd(0, 0, v); chk("R10 paddr locked", v, 32'h10);
        wr_reg(0, 3, cfgw(0, 0, 0, 1, 0, 2'd2, 2'd2, 2'd0, 0, 1, 0));
        wr_reg(0, 2, 32'd5);
        rd(0, 2, v); chk("R10 count open when disabled", v, 5);
        @(negedge clk); flag_clr = 7'h01;
        @(negedge clk); flag_clr = '0;
        chk("R11 clear flags", {29'd0, ht_flag[0], tc_flag[0], te_flag[0]}, 0);
        chk("R11 irq drops", 32'(irq[0]), 0);
        nb = n_bus;
        fire(7'h01, 7'h00, 12);
        chk("R12 disabled ignores request", 32'(n_bus), 32'(nb));
        wr_reg(0, 3, cfgw(1, 0, 0, 1, 0, 2'd2, 2'd2, 2'd0, 0, 1, 0));
        repeat (12) @(negedge clk);
        rd(0, 2, v); chk("R12 no stale pending", v, 5);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periph_to_mem();
        t_mem_to_periph_bytes();
        t_sizes();
        t_circular();
        t_priority();
        t_error();
        t_protect_clear_ignore();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule